// File: doc/BRIEF.md
# Dual-Channel Serial Port with Double-Buffered Transmit

This block provides two independent asynchronous serial channels, A and B, behind one small register window. Each channel has a two-stage transmitter and a simple receiver. The first stage is a holding register and the second is a shift register. A byte written while the shifter is still sending waits in the holding stage. It moves into the shifter as soon as the current frame ends, so software can queue one byte ahead without gaps on the line. The receiver deserialises incoming frames into a data register and raises a data-ready flag.

The bus side has one data register per channel and one shared status/control register. The status word is split into two 16-bit halves, one per channel. A write to the control register can reset either half independently. Data-register accesses are only legal in one address space. Any other access, or an access to an undecoded offset, is answered with an access-error pulse. Writes that set bits which must be zero pulse a parity-error output. Each channel drives its own interrupt pulse. The bit time is a fixed number of clock cycles, set by a parameter.

Top module: `duart_top`

## Requirements
- R1: After reset the status word reads 0x00060006, both transmit lines are high, and `bus_err`, `par_err`, `irq_a` and `irq_b` are low.
- R2: A transmitted frame is one low start bit, then eight data bits LSB first, then one high stop bit. Each bit lasts BIT_CYCLES clocks. The line is high whenever the shifter is empty.
- R3: A data write when the channel's shifter is empty starts a frame at once and clears shift-empty. Shift-empty is bit 1 for A and bit 17 for B. A data write while the shifter is busy stores the byte in the holding register and clears holding-empty. Holding-empty is bit 2 for A and bit 18 for B.
- R4: When a frame ends with a held byte waiting, that byte starts a new frame immediately and holding-empty is set again. When no byte is waiting, shift-empty is set.
- R5: Channel A status is bits 15:0 of the status word and channel B status is bits 31:16. Data-ready is bit 0 for A and bit 16 for B. All other status bits read as zero.
- R6: A frame arriving on a channel's receive line sets that channel's data-ready flag. A legal read of the channel's data register (offset 0xE0 for A, 0xE4 for B) returns the byte in bits 7:0, with zeros above, and clears data-ready.
- R7: A control write (offset 0xE8) with bit 7 set resets channel A's status half to shift-empty and holding-empty with data-ready low. It also stops any transmission in progress and returns the line high. Bit 23 does the same for channel B. The other channel's half is unchanged.
- R8: A data-register access with an address-space identifier other than 0x0B, or any access to an offset other than 0xE0, 0xE4 or 0xE8, gives a one-cycle `bus_err` pulse, reads zero and has no effect. The control register is accessible with any identifier.
- R9: A data write with any of bits 31:8 set, or a control write with any bit of mask 0xFF00FF00 set, gives a one-cycle `par_err` pulse. The write still takes effect using its legal bits.
- R10: `irq_a` and `irq_b` each give a one-cycle pulse when their channel's shifter becomes empty and when their channel's receiver completes a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_asi | input | 8 | Address-space identifier |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Access-error pulse |
| par_err | output | 1 | Parity-error pulse |
| rx_a | input | 1 | Channel A receive line |
| rx_b | input | 1 | Channel B receive line |
| tx_a | output | 1 | Channel A transmit line |
| tx_b | output | 1 | Channel B transmit line |
| irq_a | output | 1 | Channel A interrupt pulse |
| irq_b | output | 1 | Channel B interrupt pulse |

## Verification
The assertions check the following on every cycle:
- A full holding stage always implies a busy shifter, and an empty shifter always leaves the line high.
- A frame-end pulse leaves both transmit stages empty.
- A clear leaves the cleared channel empty.
- A legal data read drops data-ready.
- Bad-identifier accesses and illegal write bits produce their error pulses.

Only the bench's scenarios can show the rest. This includes the exact frame on the line and the ordering of a queued byte behind the one being sent. It also includes the loopback reception and the status values as software sees them. Finally, the scenarios show that errored accesses and one channel's clear leave all other state untouched.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam logic [7:0]  OFS_DATA_A = 8'hE0;
  localparam logic [7:0]  OFS_DATA_B = 8'hE4;
  localparam logic [7:0]  OFS_CTRL   = 8'hE8;
  localparam logic [7:0]  DATA_SPACE = 8'h0B;
  localparam logic [31:0] CTRL_RSVD  = 32'hFF00FF00;
  localparam int          CLR_BIT_A  = 7;
  localparam int          CLR_BIT_B  = 23;
  localparam int          NUM_CH     = 2;
  localparam int          BYTE_W     = 8;
endpackage

// File: rtl/duart_tx.sv
module duart_tx #(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       tx,
  output logic       shift_empty,
  output logic       hold_empty,
  output logic       done
);
  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [3:0] STOP_IDX = 4'd9;

  logic [9:0]    frame;
  logic [7:0]    hold;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic          bit_end, frame_end;

  assign bit_end   = (cnt == LAST);
  assign frame_end = !shift_empty && bit_end && (idx == STOP_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      frame <= '1; hold <= '0; cnt <= '0; idx <= '0;
      shift_empty <= 1'b1; hold_empty <= 1'b1; tx <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (shift_empty) begin
        if (wr_en) begin
          frame <= {1'b1, wr_byte, 1'b0};
          tx <= 1'b0; shift_empty <= 1'b0; cnt <= '0; idx <= '0;
        end
      end else if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (idx == STOP_IDX) begin
          if (!hold_empty) begin
            frame <= {1'b1, hold, 1'b0};
            tx <= 1'b0; idx <= '0; hold_empty <= 1'b1;
            if (wr_en) begin
              hold <= wr_byte; hold_empty <= 1'b0;
            end
          end else if (wr_en) begin
            frame <= {1'b1, wr_byte, 1'b0};
            tx <= 1'b0; idx <= '0;
          end else begin
            shift_empty <= 1'b1; tx <= 1'b1; done <= 1'b1;
          end
        end else begin
          frame <= {1'b1, frame[9:1]};
          tx <= frame[1];
          idx <= idx + 1'b1;
        end
      end
      if (wr_en && !shift_empty && !frame_end) begin
        hold <= wr_byte; hold_empty <= 1'b0;
      end
    end
  end

  AST_HOLD_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst) !hold_empty |-> !shift_empty); // R3
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst) shift_empty |-> tx); // R2
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (rst) done |-> (shift_empty && hold_empty)); // R4
endmodule

// File: rtl/duart_rx.sv
module duart_rx #(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);
  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2 - 1);

  logic          s1, s2, busy;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; busy <= 1'b0; cnt <= '0; idx <= '0;
      sh <= '0; rx_byte <= '0; rx_valid <= 1'b0;
    end else begin
      s1 <= rx; s2 <= s1;
      rx_valid <= 1'b0;
      if (!busy) begin
        if (!s2) begin
          busy <= 1'b1; cnt <= '0; idx <= '0;
        end
      end else if (cnt == ((idx == 4'd0) ? MID : LAST)) begin
        cnt <= '0;
        if (idx == 4'd0) begin
          if (s2) busy <= 1'b0;
          else idx <= 4'd1;
        end else if (idx < 4'd9) begin
          sh <= {s2, sh[7:1]};
          idx <= idx + 1'b1;
        end else begin
          busy <= 1'b0; rx_valid <= 1'b1; rx_byte <= sh;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R6
endmodule

// File: rtl/duart_top.sv
module duart_top
  import duart_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_asi,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  output logic        par_err,
  input  logic        rx_a,
  input  logic        rx_b,
  output logic        tx_a,
  output logic        tx_b,
  output logic        irq_a,
  output logic        irq_b
);
  logic is_a, is_b, is_ctl, bad_space, acc_err, ctl_wr, par_hit;
  logic [NUM_CH-1:0] wr_ch, rd_ch, clr_ch, tx_done, rx_valid, sh_e, hd_e, dr, tx_line, rx_line;
  logic [BYTE_W-1:0] rx_data [NUM_CH];
  logic [31:0] status;

  assign is_a      = (bus_addr == OFS_DATA_A);
  assign is_b      = (bus_addr == OFS_DATA_B);
  assign is_ctl    = (bus_addr == OFS_CTRL);
  assign bad_space = (is_a || is_b) && (bus_asi != DATA_SPACE);
  assign acc_err   = bus_sel && (bad_space || !(is_a || is_b || is_ctl));
  assign ctl_wr    = bus_sel && bus_wr && is_ctl;
  assign wr_ch     = {bus_sel && bus_wr && is_b && !bad_space, bus_sel && bus_wr && is_a && !bad_space};
  assign rd_ch     = {bus_sel && !bus_wr && is_b && !bad_space, bus_sel && !bus_wr && is_a && !bad_space};
  assign clr_ch    = {ctl_wr && bus_wdata[CLR_BIT_B], ctl_wr && bus_wdata[CLR_BIT_A]};
  assign par_hit   = ((|wr_ch) && (|bus_wdata[31:8])) || (ctl_wr && (|(bus_wdata & CTRL_RSVD)));
  assign rx_line   = {rx_b, rx_a};
  assign tx_a      = tx_line[0];
  assign tx_b      = tx_line[1];
  assign status    = {13'b0, hd_e[1], sh_e[1], dr[1], 13'b0, hd_e[0], sh_e[0], dr[0]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    duart_tx #(.BIT_CYCLES(BIT_CYCLES)) i_tx (
      .clk(clk), .rst(rst), .clr(clr_ch[ch]), .wr_en(wr_ch[ch]),
      .wr_byte(bus_wdata[7:0]), .tx(tx_line[ch]), .shift_empty(sh_e[ch]),
      .hold_empty(hd_e[ch]), .done(tx_done[ch]));

    duart_rx #(.BIT_CYCLES(BIT_CYCLES)) i_rx (
      .clk(clk), .rst(rst), .rx(rx_line[ch]),
      .rx_byte(rx_data[ch]), .rx_valid(rx_valid[ch]));

    always_ff @(posedge clk) begin
      if (rst || clr_ch[ch])  dr[ch] <= 1'b0;
      else if (rx_valid[ch])  dr[ch] <= 1'b1;
      else if (rd_ch[ch])     dr[ch] <= 1'b0;
    end

    AST_RD_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
      (rd_ch[ch] && !rx_valid[ch]) |=> !dr[ch]); // R6
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      clr_ch[ch] |=> (sh_e[ch] && hd_e[ch] && !dr[ch])); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0; bus_err <= 1'b0; par_err <= 1'b0; irq_a <= 1'b0; irq_b <= 1'b0;
    end else begin
      bus_err <= acc_err;
      par_err <= par_hit;
      irq_a   <= tx_done[0] || rx_valid[0];
      irq_b   <= tx_done[1] || rx_valid[1];
      if (bus_sel && !bus_wr) begin
        if (rd_ch[0])    bus_rdata <= {24'b0, rx_data[0]};
        else if (rd_ch[1]) bus_rdata <= {24'b0, rx_data[1]};
        else if (is_ctl) bus_rdata <= status;
        else             bus_rdata <= '0;
      end
    end
  end

  AST_BAD_SPACE_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && (is_a || is_b) && (bus_asi != DATA_SPACE)) |=> bus_err); // R8
  AST_RSVD_PAR: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && is_ctl && (|(bus_wdata & CTRL_RSVD))) |=> par_err); // R9
endmodule

// File: tb/test_duart_top.sv
`timescale 1ns/1ps
module test_duart_top;
  localparam int BITC = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_asi = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err, par_err, rx_a, rx_b, tx_a, tx_b, irq_a, irq_b;
  int n_chk = 0, n_fail = 0, n_irq_a = 0, n_irq_b = 0;
  logic [31:0] rv; logic ev, pv;
  logic [7:0] exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rx_a = tx_b;
  assign rx_b = tx_a;

  duart_top #(.BIT_CYCLES(BITC)) i_duart_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_asi(bus_asi), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .par_err(par_err), .rx_a(rx_a), .rx_b(rx_b), .tx_a(tx_a), .tx_b(tx_b),
    .irq_a(irq_a), .irq_b(irq_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [7:0] asi,
                        input logic [31:0] wd);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = addr; bus_asi = asi; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rv = bus_rdata; ev = bus_err; pv = par_err;
  endtask

  task automatic send_a(input logic [31:0] wd);
    exp_q.push_back(wd[7:0]);
    bus_op(1, 8'hE0, 8'h0B, wd);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (irq_a) n_irq_a++;
    if (irq_b) n_irq_b++;
  end

  // scoreboard monitor on channel A line (R2)
  initial begin
    forever begin
      logic [7:0] got;
      @(negedge tx_a);
      #(BITC * 2.5);
      check("R2 start bit", {31'b0, tx_a}, 32'h0);
      for (int i = 0; i < 8; i++) begin
        #(BITC * 5.0);
        got[i] = tx_a;
      end
      #(BITC * 5.0);
      check("R2 stop bit", {31'b0, tx_a}, 32'h1);
      if (exp_q.size() == 0) check("R2 unexpected frame", {24'b0, got}, 32'hxx);
      else check("R2 frame byte", {24'b0, got}, {24'b0, exp_q.pop_front()});
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 tx lines", {30'b0, tx_b, tx_a}, 32'h3);
    check("R1 flags", {28'b0, bus_err, par_err, irq_a, irq_b}, 32'h0);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R1 status", rv, 32'h00060006);

    // R3/R4: back-to-back bytes on A, looped into B receiver
    n_irq_a = 0; n_irq_b = 0;
    send_a(32'h55);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R3 shift busy", rv, 32'h00060004);
    send_a(32'hA3);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R3 holding full", rv, 32'h00060000);
    wait_cyc(250);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R4 both empty, R5 B ready bit16", rv, 32'h00070006);
    check("R10 irq_a count", n_irq_a, 1);
    check("R10 irq_b count", n_irq_b, 2);
    bus_op(0, 8'hE4, 8'h0B, 0);
    check("R6 read B byte", rv, 32'h000000A3);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R6 B ready cleared", rv, 32'h00060006);

    // R6 via channel B -> A receiver; R8 errors
    bus_op(1, 8'hE4, 8'h0B, 32'h3C);
    wait_cyc(250);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R5 A ready bit0", rv, 32'h00060007);
    bus_op(0, 8'hE0, 8'h0A, 0);
    check("R8 bad space err", {31'b0, ev}, 1);
    check("R8 bad space data", rv, 0);
    bus_op(1, 8'hE4, 8'h01, 32'h77);
    check("R8 bad space write err", {31'b0, ev}, 1);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R8 no effect", rv, 32'h00060007);
    check("R8 ctrl any space", {31'b0, ev}, 0);
    check("R8 tx_b idle", {31'b0, tx_b}, 1);
    bus_op(0, 8'hF0, 8'h0B, 0);
    check("R8 unknown offset", {31'b0, ev}, 1);
    bus_op(0, 8'hE0, 8'h0B, 0);
    check("R6 read A byte", rv, 32'h0000003C);
    check("R6 no error", {31'b0, ev}, 0);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R6 A ready cleared", rv, 32'h00060006);

    // R7: clear channel B mid-transmission, A half untouched
    bus_op(1, 8'hE4, 8'h0B, 32'h11);
    wait_cyc(250);
    bus_op(1, 8'hE4, 8'h0B, 32'h22);
    bus_op(1, 8'hE4, 8'h0B, 32'h33);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R3 B busy and held", rv, 32'h00000007);
    bus_op(1, 8'hE8, 8'h00, 32'h00800000);
    check("R7 clear not parity", {31'b0, pv}, 0);
    check("R7 tx_b high", {31'b0, tx_b}, 1);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R7 B cleared A kept", rv, 32'h00060007);
    wait_cyc(250);
    check("R7 tx_b stays idle", {31'b0, tx_b}, 1);
    bus_op(1, 8'hE8, 8'h00, 32'h00000080);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R7 A cleared", rv, 32'h00060006);

    // R9 parity pulses
    n_irq_a = 0; n_irq_b = 0;
    bus_op(1, 8'hE8, 8'h00, 32'h00000100);
    check("R9 ctrl reserved bit", {31'b0, pv}, 1);
    send_a(32'h000001C5);
    check("R9 data upper bits", {31'b0, pv}, 1);
    send_a(32'h5A);
    check("R9 clean write", {31'b0, pv}, 0);
    wait_cyc(250);
    bus_op(0, 8'hE8, 8'h00, 0);
    check("R9 write took effect", rv, 32'h00070006);
    check("R10 irq_a single", n_irq_a, 1);
    check("R10 irq_b per byte", n_irq_b, 2);
    bus_op(0, 8'hE4, 8'h0B, 0);
    check("R9 low byte kept", rv, 32'h0000005A);
    check("R2 all frames seen", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule